// File: doc/BRIEF.md
# GPIB Device Address Recognizer

This block watches the command bytes that arrive while the bus attention line is asserted and decides whether this device has been addressed as a talker or as a listener. It takes the five-bit device addresses and a two-bit addressing mode from configuration inputs. It updates its talk and listen flags as addresses, unlisten, untalk and other devices' addresses pass by.

The block has four addressing modes. The first two are plain primary addressing, with one address or with two. The third is extended addressing, in which a primary byte and then a secondary byte complete the address. The fourth is a pass-through mode. In that mode the secondary byte is handed to software through an interrupt, and the acceptor handshake is held until software answers with a Valid or a Non-Valid pulse. A registered change pulse tells the host when the talk, listen, controller-in-charge or major/minor status has moved.

Top module: `gpib_addr_recognizer`

## Requirements
- R1: A synchronous active-high reset clears the talk, listen, both pending flags, the minor flag, the change pulse, the interrupt and the hold.
- R2: A command byte is taken only when `cmd_stb` and `atn` are both high. A strobe with `atn` low changes nothing. Bit 7 of the byte is ignored.
- R3: In mode 00 (single), byte 0x20+A sets `listen_addr` and byte 0x40+A sets `talk_addr`, where A is `addr0`.
- R4: When the device's own listen addressing completes, `talk_addr` is cleared.
- R5: Byte 0x3F (unlisten) clears `listen_addr`. Byte 0x5F (untalk) clears `talk_addr`. Any other talk-group byte that does not match this device clears `talk_addr`.
- R6: An address register holding 5'b11111 never matches, either as a primary or as a secondary address.
- R7: `addrN_no_talk` and `addrN_no_listen` suppress talk matching and listen matching for their own register. In mode 10 the disable bits of register 1 suppress completion by the secondary byte.
- R8: In mode 01 (dual), `addr1` is a second primary address. `minor_sel` goes to 1 when the device is addressed through `addr1` and to 0 when it is addressed through `addr0`.
- R9: In mode 10 (extended), a primary match on `addr0` sets `talk_pend` or `listen_pend` instead of the flag. The next secondary byte 0x60+S (S = `addr1`) sets that flag. Any other secondary byte clears that flag. In both cases the pending flag is cleared. A secondary byte with nothing pending has no effect.
- R10: A talk-group or listen-group byte, including unlisten and untalk, replaces the pending flags with the result of its own match, so at most one pending flag is ever set.
- R11: In mode 11 (pass-through), a secondary byte arriving while a pending flag is set raises `pt_irq` for exactly one cycle and raises `ac_hold`. While `ac_hold` is high, command strobes are ignored.
- R12: While `ac_hold` is high, `sw_valid` completes the pending function and `sw_invalid` returns that function to idle. Either pulse clears the pending flag and the hold. Both pulses are ignored when `ac_hold` is low.
- R13: `addr_chg` is high for one cycle, one cycle after any of `talk_addr`, `listen_addr`, `minor_sel` or the sampled `cic` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_byte | input | 8 | Received command byte |
| cmd_stb | input | 1 | Strobe marking one accepted byte |
| atn | input | 1 | Bus attention level |
| cic | input | 1 | Controller-in-charge status |
| addr_mode | input | 2 | 00 single, 01 dual, 10 extended, 11 pass-through |
| addr0 | input | 5 | Primary (major) address |
| addr0_no_talk | input | 1 | Disable talk match on addr0 |
| addr0_no_listen | input | 1 | Disable listen match on addr0 |
| addr1 | input | 5 | Minor primary address or secondary address |
| addr1_no_talk | input | 1 | Disable talk match on addr1 |
| addr1_no_listen | input | 1 | Disable listen match on addr1 |
| sw_valid | input | 1 | Software rules the secondary address valid |
| sw_invalid | input | 1 | Software rules the secondary address invalid |
| talk_addr | output | 1 | Addressed to talk |
| listen_addr | output | 1 | Addressed to listen |
| talk_pend | output | 1 | Talk primary received, secondary awaited |
| listen_pend | output | 1 | Listen primary received, secondary awaited |
| minor_sel | output | 1 | Last primary match came from addr1 |
| addr_chg | output | 1 | Address status change pulse |
| pt_irq | output | 1 | Pass-through interrupt pulse |
| ac_hold | output | 1 | Hold the acceptor handshake |

## Verification
The checker enforces several rules on every cycle. At most one pending flag is set. The interrupt pulse lasts one cycle and never occurs without the hold, and the hold can only begin with that pulse. The hold freezes the flags until software answers. With no accepted strobe and no software pulse the flags stay unchanged. Every status change is followed by `addr_chg`. Only the bench scenarios can show the address arithmetic for each mode: the unlisten, untalk and other-talker effects, the all-ones and disable rules, the major/minor selection, and how a valid or a non-valid answer resolves a pending talk or listen.

// File: rtl/gpib_addr_pkg.sv
package gpib_addr_pkg;

    localparam int CMD_W   = 8;
    localparam int ADDR_W  = 5;
    localparam int NREG    = 2;
    localparam int FLAG_N  = 4;
    localparam logic [CMD_W-1:0] CMD_MASK = {1'b0, {(CMD_W-1){1'b1}}};
    localparam logic [ADDR_W-1:0] ADDR_ONES = '1;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_DUAL   = 2'b01,
        MODE_EXT    = 2'b10,
        MODE_PASS   = 2'b11
    } addr_mode_e;

    typedef enum logic [2:0] {
        CLS_OTHER,
        CLS_LISTEN,
        CLS_TALK,
        CLS_SEC,
        CLS_UNL,
        CLS_UNT
    } cmd_cls_e;

    typedef struct packed {
        cmd_cls_e          cls;
        logic [ADDR_W-1:0] field;
    } cmd_dec_t;

    typedef struct packed {
        logic [NREG-1:0] listen_hit;
        logic [NREG-1:0] talk_hit;
        logic            sec_talk_ok;
        logic            sec_listen_ok;
    } match_t;

    typedef struct packed {
        logic talk;
        logic listen;
        logic talk_pend;
        logic listen_pend;
        logic minor;
        logic hold;
    } addr_state_t;

    function automatic logic addr_usable(input logic [ADDR_W-1:0] a);
        return a != ADDR_ONES;
    endfunction

    function automatic cmd_dec_t classify(input logic [CMD_W-1:0] raw);
        cmd_dec_t d;
        logic [CMD_W-1:0] b;
        b       = raw & CMD_MASK;
        d.field = b[ADDR_W-1:0];
        unique case (b[6:5])
            2'b01:   d.cls = (b[ADDR_W-1:0] == ADDR_ONES) ? CLS_UNL : CLS_LISTEN;
            2'b10:   d.cls = (b[ADDR_W-1:0] == ADDR_ONES) ? CLS_UNT : CLS_TALK;
            2'b11:   d.cls = CLS_SEC;
            default: d.cls = CLS_OTHER;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gpib_cmd_decode.sv
module gpib_cmd_decode
    import gpib_addr_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_byte,
    output cmd_dec_t         dec
);
    always_comb dec = classify(cmd_byte);
endmodule

// File: rtl/gpib_addr_match.sv
module gpib_addr_match
    import gpib_addr_pkg::*;
(
    input  addr_mode_e                   mode,
    input  logic [ADDR_W-1:0]            field,
    input  logic [NREG-1:0][ADDR_W-1:0]  regs,
    input  logic [NREG-1:0]              no_talk,
    input  logic [NREG-1:0]              no_listen,
    output match_t                       hit
);
    logic [NREG-1:0] reg_live;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        // register 0 is always a primary; later ones only in dual mode
        assign reg_live[i] = addr_usable(regs[i]) &&
                             ((i == 0) || (mode == MODE_DUAL));
        assign hit.listen_hit[i] = reg_live[i] && (field == regs[i]) && !no_listen[i];
        assign hit.talk_hit[i]   = reg_live[i] && (field == regs[i]) && !no_talk[i];
    end

    logic sec_eq;
    assign sec_eq            = addr_usable(regs[NREG-1]) && (field == regs[NREG-1]);
    assign hit.sec_talk_ok   = sec_eq && !no_talk[NREG-1];
    assign hit.sec_listen_ok = sec_eq && !no_listen[NREG-1];
endmodule

// File: rtl/gpib_addr_state.sv
module gpib_addr_state
    import gpib_addr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  cmd_dec_t    dec,
    input  match_t      hit,
    input  addr_mode_e  mode,
    input  logic        sw_valid,
    input  logic        sw_invalid,
    output addr_state_t st,
    output logic        irq
);
    addr_state_t nxt;
    logic        irq_set;
    logic        primary_mode;

    assign primary_mode = (mode == MODE_SINGLE) || (mode == MODE_DUAL);

    always_comb begin
        nxt     = st;
        irq_set = 1'b0;
        if (st.hold) begin
            if (sw_valid) begin
                if (st.talk_pend) nxt.talk = 1'b1;
                if (st.listen_pend) begin
                    nxt.listen = 1'b1;
                    nxt.talk   = 1'b0;
                end
                nxt.talk_pend   = 1'b0;
                nxt.listen_pend = 1'b0;
                nxt.hold        = 1'b0;
            end else if (sw_invalid) begin
                if (st.talk_pend)   nxt.talk   = 1'b0;
                if (st.listen_pend) nxt.listen = 1'b0;
                nxt.talk_pend   = 1'b0;
                nxt.listen_pend = 1'b0;
                nxt.hold        = 1'b0;
            end
        end else if (take) begin
            unique case (dec.cls)
                CLS_UNL: begin
                    nxt.listen      = 1'b0;
                    nxt.talk_pend   = 1'b0;
                    nxt.listen_pend = 1'b0;
                end
                CLS_UNT: begin
                    nxt.talk        = 1'b0;
                    nxt.talk_pend   = 1'b0;
                    nxt.listen_pend = 1'b0;
                end
                CLS_LISTEN: begin
                    nxt.talk_pend   = 1'b0;
                    nxt.listen_pend = 1'b0;
                    if (primary_mode) begin
                        if (|hit.listen_hit) begin
                            nxt.listen = 1'b1;
                            nxt.talk   = 1'b0;
                            nxt.minor  = !hit.listen_hit[0];
                        end
                    end else begin
                        nxt.listen_pend = hit.listen_hit[0];
                    end
                end
                CLS_TALK: begin
                    nxt.talk_pend   = 1'b0;
                    nxt.listen_pend = 1'b0;
                    if (primary_mode) begin
                        if (|hit.talk_hit) begin
                            nxt.talk  = 1'b1;
                            nxt.minor = !hit.talk_hit[0];
                        end else begin
                            nxt.talk = 1'b0;
                        end
                    end else begin
                        nxt.talk_pend = hit.talk_hit[0];
                        if (!hit.talk_hit[0]) nxt.talk = 1'b0;
                    end
                end
                CLS_SEC: begin
                    if (st.talk_pend || st.listen_pend) begin
                        if (mode == MODE_EXT) begin
                            if (st.talk_pend) nxt.talk = hit.sec_talk_ok;
                            if (st.listen_pend) begin
                                if (hit.sec_listen_ok) begin
                                    nxt.listen = 1'b1;
                                    nxt.talk   = 1'b0;
                                end else begin
                                    nxt.listen = 1'b0;
                                end
                            end
                            nxt.talk_pend   = 1'b0;
                            nxt.listen_pend = 1'b0;
                        end else if (mode == MODE_PASS) begin
                            nxt.hold = 1'b1;
                            irq_set  = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            irq <= 1'b0;
        end else begin
            st  <= nxt;
            irq <= irq_set;
        end
    end
endmodule

// File: rtl/gpib_status_change.sv
module gpib_status_change #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] flags,
    output logic         pulse
);
    logic [N-1:0] snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap  <= '0;
            pulse <= 1'b0;
        end else begin
            snap  <= flags;
            pulse <= |(flags ^ snap);
        end
    end
endmodule

// File: rtl/gpib_addr_recognizer.sv
module gpib_addr_recognizer
    import gpib_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  cmd_byte,
    input  logic              cmd_stb,
    input  logic              atn,
    input  logic              cic,
    input  logic [1:0]        addr_mode,
    input  logic [ADDR_W-1:0] addr0,
    input  logic              addr0_no_talk,
    input  logic              addr0_no_listen,
    input  logic [ADDR_W-1:0] addr1,
    input  logic              addr1_no_talk,
    input  logic              addr1_no_listen,
    input  logic              sw_valid,
    input  logic              sw_invalid,
    output logic              talk_addr,
    output logic              listen_addr,
    output logic              talk_pend,
    output logic              listen_pend,
    output logic              minor_sel,
    output logic              addr_chg,
    output logic              pt_irq,
    output logic              ac_hold
);
    addr_mode_e                  mode;
    cmd_dec_t                    dec;
    match_t                      hit;
    addr_state_t                 st;
    logic [NREG-1:0][ADDR_W-1:0] regs;
    logic [NREG-1:0]             no_talk;
    logic [NREG-1:0]             no_listen;
    logic                        take;

    assign mode      = addr_mode_e'(addr_mode);
    assign regs      = {addr1, addr0};
    assign no_talk   = {addr1_no_talk, addr0_no_talk};
    assign no_listen = {addr1_no_listen, addr0_no_listen};
    assign take      = cmd_stb && atn;

    gpib_cmd_decode i_decode (
        .cmd_byte (cmd_byte),
        .dec      (dec)
    );

    gpib_addr_match i_match (
        .mode      (mode),
        .field     (dec.field),
        .regs      (regs),
        .no_talk   (no_talk),
        .no_listen (no_listen),
        .hit       (hit)
    );

    gpib_addr_state i_state (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .dec        (dec),
        .hit        (hit),
        .mode       (mode),
        .sw_valid   (sw_valid),
        .sw_invalid (sw_invalid),
        .st         (st),
        .irq        (pt_irq)
    );

    gpib_status_change #(.N(FLAG_N)) i_chg (
        .clk   (clk),
        .rst   (rst),
        .flags ({st.talk, st.listen, cic, st.minor}),
        .pulse (addr_chg)
    );

    assign talk_addr   = st.talk;
    assign listen_addr = st.listen;
    assign talk_pend   = st.talk_pend;
    assign listen_pend = st.listen_pend;
    assign minor_sel   = st.minor;
    assign ac_hold     = st.hold;
endmodule

// File: rtl/gpib_addr_recognizer_chk.sv
module gpib_addr_recognizer_chk (
    input logic clk,
    input logic rst,
    input logic cmd_stb,
    input logic atn,
    input logic cic,
    input logic sw_valid,
    input logic sw_invalid,
    input logic talk_addr,
    input logic listen_addr,
    input logic talk_pend,
    input logic listen_pend,
    input logic minor_sel,
    input logic addr_chg,
    input logic pt_irq,
    input logic ac_hold
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> !talk_addr && !listen_addr && !talk_pend && !listen_pend &&
                !minor_sel && !pt_irq && !ac_hold && !addr_chg);

    assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (!(cmd_stb && atn) && !sw_valid && !sw_invalid) |=>
            $stable(talk_addr) && $stable(listen_addr) &&
            $stable(talk_pend) && $stable(listen_pend));

    assert_pend_excl_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({talk_pend, listen_pend}));

    assert_irq_with_hold_R11: assert property (@(posedge clk) disable iff (rst)
        pt_irq |-> ac_hold);

    assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        pt_irq |=> !pt_irq);

    assert_hold_entry_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(ac_hold) |-> pt_irq);

    assert_hold_freeze_R12: assert property (@(posedge clk) disable iff (rst)
        (ac_hold && !sw_valid && !sw_invalid) |=>
            ac_hold && $stable(talk_addr) && $stable(listen_addr));

    assert_change_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        (!$stable(talk_addr) || !$stable(listen_addr) ||
         !$stable(minor_sel) || !$stable(cic)) |=> addr_chg);
endmodule

bind gpib_addr_recognizer gpib_addr_recognizer_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_stb     (cmd_stb),
    .atn         (atn),
    .cic         (cic),
    .sw_valid    (sw_valid),
    .sw_invalid  (sw_invalid),
    .talk_addr   (talk_addr),
    .listen_addr (listen_addr),
    .talk_pend   (talk_pend),
    .listen_pend (listen_pend),
    .minor_sel   (minor_sel),
    .addr_chg    (addr_chg),
    .pt_irq      (pt_irq),
    .ac_hold     (ac_hold)
);

// File: tb/test_gpib_addr_recognizer.sv
`timescale 1ns/1ps
module test_gpib_addr_recognizer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cmd_byte = '0;
    logic       cmd_stb = 1'b0;
    logic       atn = 1'b1;
    logic       cic = 1'b0;
    logic [1:0] addr_mode = 2'b00;
    logic [4:0] addr0 = 5'd3;
    logic       addr0_no_talk = 1'b0;
    logic       addr0_no_listen = 1'b0;
    logic [4:0] addr1 = 5'd9;
    logic       addr1_no_talk = 1'b0;
    logic       addr1_no_listen = 1'b0;
    logic       sw_valid = 1'b0;
    logic       sw_invalid = 1'b0;
    logic       talk_addr, listen_addr, talk_pend, listen_pend;
    logic       minor_sel, addr_chg, pt_irq, ac_hold;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpib_addr_recognizer i_gpib_addr_recognizer (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [1:0] m, input logic [4:0] a0, input logic [4:0] a1,
                         input logic nt0, input logic nl0, input logic nt1, input logic nl1);
        @(negedge clk);
        addr_mode = m; addr0 = a0; addr1 = a1;
        addr0_no_talk = nt0; addr0_no_listen = nl0;
        addr1_no_talk = nt1; addr1_no_listen = nl1;
        atn = 1'b1; cic = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        cmd_byte = b; cmd_stb = 1'b1;
        @(negedge clk);
        cmd_stb = 1'b0;
    endtask

    task automatic answer(input bit ok);
        @(negedge clk);
        if (ok) sw_valid = 1'b1; else sw_invalid = 1'b1;
        @(negedge clk);
        sw_valid = 1'b0; sw_invalid = 1'b0;
    endtask

    task automatic t_reset;
        setup(2'b00, 5'd3, 5'd9, 0, 0, 0, 0);
        chk("R1 outputs after reset",
            {talk_addr, listen_addr, talk_pend, listen_pend, minor_sel, addr_chg, pt_irq, ac_hold}, 0);
        send(8'h23);
        chk("R1 listen before reset", listen_addr, 1);
        setup(2'b00, 5'd3, 5'd9, 0, 0, 0, 0);
        chk("R1 listen cleared by reset", listen_addr, 0);
    endtask

    task automatic t_single;
        setup(2'b00, 5'd3, 5'd9, 0, 0, 0, 0);
        send(8'h23); chk("R3 listen address", listen_addr, 1);
        send(8'h43); chk("R3 talk address", talk_addr, 1);
        chk("R3 listen kept", listen_addr, 1);
        send(8'h23); chk("R4 own listen clears talk", talk_addr, 0);
        send(8'h3F); chk("R5 unlisten", listen_addr, 0);
        send(8'h43); send(8'h45); chk("R5 other talker", talk_addr, 0);
        send(8'h43); send(8'h5F); chk("R5 untalk", talk_addr, 0);
        atn = 1'b0; send(8'h23); chk("R2 atn low ignored", listen_addr, 0);
        atn = 1'b1; send(8'hA3); chk("R2 bit7 ignored", listen_addr, 1);
    endtask

    task automatic t_disable;
        setup(2'b00, 5'd3, 5'd9, 0, 1, 0, 0);
        send(8'h23); chk("R7 listen disabled", listen_addr, 0);
        send(8'h43); chk("R7 talk still enabled", talk_addr, 1);
        setup(2'b00, 5'd3, 5'd9, 1, 0, 0, 0);
        send(8'h43); chk("R7 talk disabled", talk_addr, 0);
        send(8'h23); chk("R7 listen still enabled", listen_addr, 1);
        setup(2'b10, 5'd3, 5'd9, 0, 0, 1, 0);
        send(8'h43); send(8'h69); chk("R7 secondary talk disabled", talk_addr, 0);
    endtask

    task automatic t_dual;
        setup(2'b01, 5'd3, 5'd9, 0, 0, 0, 0);
        send(8'h29);
        chk("R8 listen via minor", listen_addr, 1);
        chk("R8 minor set", minor_sel, 1);
        chk("R13 no pulse yet", addr_chg, 0);
        @(negedge clk); chk("R13 pulse", addr_chg, 1);
        @(negedge clk); chk("R13 pulse ends", addr_chg, 0);
        send(8'h43);
        chk("R8 talk via major", talk_addr, 1);
        chk("R8 minor cleared", minor_sel, 0);
        send(8'h49); chk("R8 talk via minor", minor_sel, 1);
    endtask

    task automatic t_ext;
        setup(2'b10, 5'd3, 5'd9, 0, 0, 0, 0);
        send(8'h43);
        chk("R9 talk pending", talk_pend, 1);
        chk("R9 talk not yet", talk_addr, 0);
        send(8'h69);
        chk("R9 talk completed", talk_addr, 1);
        chk("R9 pending cleared", talk_pend, 0);
        send(8'h23); chk("R9 listen pending", listen_pend, 1);
        send(8'h6A);
        chk("R9 wrong secondary idles listen", {listen_addr, listen_pend}, 0);
        chk("R9 talk untouched", talk_addr, 1);
        send(8'h23); send(8'h43);
        chk("R10 pending swap", {talk_pend, listen_pend}, 2'b10);
        send(8'h25);
        chk("R10 other primary clears", {talk_pend, listen_pend}, 0);
        send(8'h69);
        chk("R9 secondary without pending", {talk_addr, listen_addr}, 2'b10);
        send(8'h23); send(8'h69);
        chk("R4 listen completion clears talk", {talk_addr, listen_addr}, 2'b01);
    endtask

    task automatic t_ones;
        setup(2'b10, 5'd3, 5'd31, 0, 0, 0, 0);
        send(8'h43); send(8'h7F);
        chk("R6 all-ones secondary", talk_addr, 0);
        setup(2'b01, 5'd3, 5'd31, 0, 0, 0, 0);
        send(8'h3F); send(8'h5F);
        chk("R6 all-ones primary", {talk_addr, listen_addr, minor_sel}, 0);
    endtask

    task automatic t_pass;
        setup(2'b11, 5'd3, 5'd9, 0, 0, 0, 0);
        send(8'h23); send(8'h61);
        chk("R11 irq raised", pt_irq, 1);
        chk("R11 hold raised", ac_hold, 1);
        @(negedge clk);
        chk("R11 irq one cycle", {pt_irq, ac_hold}, 2'b01);
        answer(1);
        chk("R12 valid completes listen", {listen_addr, listen_pend, ac_hold}, 3'b100);
        send(8'h43); send(8'h62);
        chk("R11 hold for talk", ac_hold, 1);
        send(8'h3F);
        chk("R11 strobe ignored in hold", {listen_addr, talk_pend}, 2'b11);
        answer(0);
        chk("R12 invalid idles talk", {talk_addr, talk_pend, ac_hold, listen_addr}, 4'b0001);
        answer(1);
        chk("R12 valid ignored without hold", {talk_addr, listen_addr}, 2'b01);
        send(8'h43); send(8'h63); answer(1);
        chk("R12 valid completes talk", talk_addr, 1);
    endtask

    task automatic t_cic;
        setup(2'b00, 5'd3, 5'd9, 0, 0, 0, 0);
        @(negedge clk); cic = 1'b1;
        @(negedge clk); chk("R13 cic change pulse", addr_chg, 1);
        @(negedge clk); chk("R13 cic pulse ends", addr_chg, 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_disable();
        t_dual();
        t_ext();
        t_ones();
        t_pass();
        t_cic();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule